// File: doc/BRIEF.md
# Ring-Oscillator Phase-Locked Loop Digital Controller

This block is the digital core of a type-I, divider-less all-digital PLL whose ring oscillator runs at a quarter of the carrier. The oscillator has 16 pseudo-differential stages, which give 32 phases. On every reference clock edge the controller captures those 32 phases and the value of an oscillator-edge counter. The captured phases act as an embedded time-to-digital converter. The controller decodes them into a 5-bit fractional phase and appends it below the integer count to form the measured oscillator phase.

A reference-phase accumulator adds an unsigned frequency control word on every reference cycle. The control word has 5 integer bits and 16 fractional bits. The controller takes the difference between the reference phase and the measured phase as a wrapping two's-complement error. It scales that error by a programmable proportional gain and adds the result to mid-scale. The sum is saturated into a 12-bit tuning code, which drives the medium and fine fields of the oscillator DAC. The coarse field comes straight from a register. Modulation is applied by rewriting the control word, because the loop is much wider than the modulation bandwidth.

A lock flag reports when the phase error has stayed small for a run of reference cycles. A simple write port sets the gain, the control word, the coarse code and the lock threshold.

Top module: `ro_adpll_ctrl`

## Requirements
- R1: A synchronous reset clears the accumulator, sets the tuning code to mid-scale 2048 (medium 32, fine 0) and clears the lock flag. It also restores the registers to gain 16, control word 0, coarse 8 and threshold 4.
- R2: The fractional phase is the index i (0 to 31) at which the smoothed snapshot has bit i equal to 1 and bit (i+1) mod 32 equal to 0. The lowest such index wins, and a snapshot with no such index decodes to 0.
- R3: Each bit is smoothed by a majority vote with its two circular neighbours, so a single flipped bit inside the run of ones or inside the run of zeros does not move the decoded phase.
- R4: The measured phase is count*32 + fraction, in 1/32-cycle units. The error is the top 13 bits of the accumulator minus the measured phase, taken modulo 2^13 as a signed value. The tuning code is 2048 + floor(error*gain/16). The medium field is code bits 11:6 and the fine field is bits 5:0. An input sampled at one reference edge reaches the code at the next edge.
- R5: The tuning code saturates at 0 and at 4095.
- R6: The gain register (unsigned, 4 fractional bits) scales the correction: gain 8 halves it, gain 0 removes it.
- R7: The accumulator adds the control word on each reference cycle. With the count held still, a word of 1.0 (0x10000) at gain 16 raises the code by 32 per cycle.
- R8: When the count advances at the rate of the control word, the code stays constant, including across the wraparound of the count from 255 to 0.
- R9: The register write port decodes address 0 as gain, 1 as control word, 2 as coarse code and 3 as lock threshold. A coarse write appears on the coarse output after that edge, and the coarse output holds between writes.
- R10: The lock flag rises once |error| < threshold has held for 16 consecutive reference cycles. It never rises when |error| equals the threshold.
- R11: The lock flag falls at the edge after the first cycle whose |error| is not below the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWrData | input | 21 | Register write data |
| phaseSnap | input | 32 | Ring phases sampled at the reference edge |
| edgeCount | input | 8 | Oscillator edge counter value |
| tuneCoarse | output | 4 | Coarse tuning field |
| tuneMid | output | 6 | Medium tuning field |
| tuneFine | output | 6 | Fine tuning field |
| locked | output | 1 | Lock indicator |

## Verification
The bench builds the block with its default parameters: 32 phases, an 8-bit counter, a 16-bit fractional control word and a 4-bit gain fraction. With an 8-bit count and a control word of 1.0, the counter and the accumulator both wrap within about 260 cycles, so the tracking test crosses the wraparound inside a short run. The 13-bit error reaches both saturation rails when the count is set to 0x80 or 0xC0. A lock run of 16 cycles keeps the acquire and loss windows to a few dozen edges.

// File: rtl/ro_adpll_pkg.sv
package ro_adpll_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clearAcc;   // clear accumulator, load mid-scale code
    logic advance;    // normal reference-cycle update
  } dpCtrl_t;
endpackage

// File: rtl/ro_adpll_control.sv
module ro_adpll_control
  import ro_adpll_pkg::*;
#(
  parameter int GAIN_W    = 8,
  parameter int FCW_W     = 21,
  parameter int COARSE_W  = 4,
  parameter int ERR_W     = 13,
  parameter int LOCK_RUN  = 16,
  parameter int GAIN_RST  = 16,
  parameter int COARSE_RST = 8,
  parameter int THR_RST   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                regWrEn,
  input  logic [1:0]          regAddr,
  input  logic [FCW_W-1:0]    regWrData,
  input  logic                errSmall,
  output dpCtrl_t             dpCtrl,
  output logic [GAIN_W-1:0]   gainQ,
  output logic [FCW_W-1:0]    fcwQ,
  output logic [COARSE_W-1:0] coarseQ,
  output logic [ERR_W-1:0]    thrQ,
  output logic                locked
);
  localparam int RUN_W = $clog2(LOCK_RUN + 1);

  logic [RUN_W-1:0] runCnt;

  always_comb begin
    dpCtrl.clearAcc = rst;
    dpCtrl.advance  = !rst;
  end

  // Register file
  always_ff @(posedge clk) begin
    if (rst) begin
      gainQ   <= GAIN_W'(GAIN_RST);
      fcwQ    <= '0;
      coarseQ <= COARSE_W'(COARSE_RST);
      thrQ    <= ERR_W'(THR_RST);
    end else if (regWrEn) begin
      case (regAddr)
        2'd0: gainQ   <= regWrData[GAIN_W-1:0];
        2'd1: fcwQ    <= regWrData;
        2'd2: coarseQ <= regWrData[COARSE_W-1:0];
        default: thrQ <= regWrData[ERR_W-1:0];
      endcase
    end
  end

  // Lock detection: run of consecutive small-error cycles
  always_ff @(posedge clk) begin
    if (rst) begin
      runCnt <= '0;
    end else if (!errSmall) begin
      runCnt <= '0;
    end else if (runCnt != RUN_W'(LOCK_RUN)) begin
      runCnt <= runCnt + 1'b1;
    end
  end

  assign locked = (runCnt == RUN_W'(LOCK_RUN));
endmodule

// File: rtl/ro_adpll_datapath.sv
module ro_adpll_datapath
  import ro_adpll_pkg::*;
#(
  parameter int NPHASE    = 32,
  parameter int CNT_W     = 8,
  parameter int FCW_INT   = 5,
  parameter int FCW_FRAC  = 16,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 4,
  parameter int MED_W     = 6,
  parameter int FINE_W    = 6,
  localparam int FRAC_W   = $clog2(NPHASE),
  localparam int ERR_W    = CNT_W + FRAC_W,
  localparam int FCW_W    = FCW_INT + FCW_FRAC,
  localparam int CODE_W   = MED_W + FINE_W
) (
  input  logic              clk,
  input  dpCtrl_t           dpCtrl,
  input  logic [NPHASE-1:0] phaseSnap,
  input  logic [CNT_W-1:0]  edgeCount,
  input  logic [GAIN_W-1:0] gain,
  input  logic [FCW_W-1:0]  fcw,
  input  logic [ERR_W-1:0]  thr,
  output logic [CODE_W-1:0] code,
  output logic              errSmall
);
  localparam int ACC_W  = CNT_W + FCW_FRAC;
  localparam int PROD_W = ERR_W + GAIN_W + 1;
  localparam int MID    = 1 << (CODE_W - 1);
  localparam int MAXC   = (1 << CODE_W) - 1;

  logic [NPHASE-1:0] snapQ, smooth;
  logic [CNT_W-1:0]  cntQ;
  logic [ACC_W-1:0]  acc;
  logic [FRAC_W-1:0] fracPh;
  logic [ERR_W-1:0]  measPh;
  logic signed [ERR_W-1:0]  phErr;
  logic [ERR_W:0]           errMag;
  logic signed [PROD_W-1:0] prod, shifted;
  logic signed [PROD_W:0]   sum;
  logic [CODE_W-1:0]        codeNext;

  // Majority smoothing over circular neighbours
  for (genvar i = 0; i < NPHASE; i++) begin : g_maj
    localparam int PREV = (i + NPHASE - 1) % NPHASE;
    localparam int NEXT = (i + 1) % NPHASE;
    assign smooth[i] = (snapQ[PREV] & snapQ[i]) | (snapQ[i] & snapQ[NEXT]) |
                       (snapQ[PREV] & snapQ[NEXT]);
  end

  // Locate the 1-to-0 transition; lowest index wins
  always_comb begin
    fracPh = '0;
    for (int i = NPHASE - 1; i >= 0; i--) begin
      if (smooth[i] && !smooth[(i + 1) % NPHASE]) fracPh = FRAC_W'(i);
    end
  end

  assign measPh = {cntQ, fracPh};
  assign phErr  = $signed(acc[ACC_W-1 -: ERR_W] - measPh);
  assign errMag = phErr[ERR_W-1] ? (ERR_W+1)'(-$signed({phErr[ERR_W-1], phErr}))
                                 : {1'b0, phErr};
  assign errSmall = (errMag < {1'b0, thr});

  assign prod    = phErr * $signed({1'b0, gain});
  assign shifted = prod >>> GAIN_FRAC;
  assign sum     = $signed({shifted[PROD_W-1], shifted}) + $signed((PROD_W+1)'(MID));

  always_comb begin
    if (sum < 0)                                codeNext = '0;
    else if (sum > $signed((PROD_W+1)'(MAXC)))  codeNext = CODE_W'(MAXC);
    else                                        codeNext = sum[CODE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (dpCtrl.clearAcc) begin
      snapQ <= '0;
      cntQ  <= '0;
      acc   <= '0;
      code  <= CODE_W'(MID);
    end else if (dpCtrl.advance) begin
      snapQ <= phaseSnap;
      cntQ  <= edgeCount;
      acc   <= acc + ACC_W'(fcw);
      code  <= codeNext;
    end
  end
endmodule

// File: rtl/ro_adpll_ctrl.sv
module ro_adpll_ctrl
  import ro_adpll_pkg::*;
#(
  parameter int NPHASE    = 32,
  parameter int CNT_W     = 8,
  parameter int FCW_INT   = 5,
  parameter int FCW_FRAC  = 16,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 4,
  parameter int COARSE_W  = 4,
  parameter int MED_W     = 6,
  parameter int FINE_W    = 6,
  parameter int LOCK_RUN  = 16,
  localparam int FCW_W    = FCW_INT + FCW_FRAC,
  localparam int ERR_W    = CNT_W + $clog2(NPHASE)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                regWrEn,
  input  logic [1:0]          regAddr,
  input  logic [FCW_W-1:0]    regWrData,
  input  logic [NPHASE-1:0]   phaseSnap,
  input  logic [CNT_W-1:0]    edgeCount,
  output logic [COARSE_W-1:0] tuneCoarse,
  output logic [MED_W-1:0]    tuneMid,
  output logic [FINE_W-1:0]   tuneFine,
  output logic                locked
);
  dpCtrl_t             dpCtrl;
  logic [GAIN_W-1:0]   gainQ;
  logic [FCW_W-1:0]    fcwQ;
  logic [ERR_W-1:0]    thrQ;
  logic                errSmall;
  logic [MED_W+FINE_W-1:0] code;

  ro_adpll_control #(
    .GAIN_W(GAIN_W), .FCW_W(FCW_W), .COARSE_W(COARSE_W),
    .ERR_W(ERR_W), .LOCK_RUN(LOCK_RUN), .GAIN_RST(1 << GAIN_FRAC)
  ) u_ctl (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .errSmall(errSmall), .dpCtrl(dpCtrl),
    .gainQ(gainQ), .fcwQ(fcwQ), .coarseQ(tuneCoarse), .thrQ(thrQ),
    .locked(locked)
  );

  ro_adpll_datapath #(
    .NPHASE(NPHASE), .CNT_W(CNT_W), .FCW_INT(FCW_INT), .FCW_FRAC(FCW_FRAC),
    .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .MED_W(MED_W), .FINE_W(FINE_W)
  ) u_dp (
    .clk(clk), .dpCtrl(dpCtrl), .phaseSnap(phaseSnap), .edgeCount(edgeCount),
    .gain(gainQ), .fcw(fcwQ), .thr(thrQ), .code(code), .errSmall(errSmall)
  );

  assign tuneMid  = code[MED_W+FINE_W-1:FINE_W];
  assign tuneFine = code[FINE_W-1:0];
endmodule

// File: rtl/ro_adpll_checker.sv
module ro_adpll_checker #(
  parameter int FCW_W    = 21,
  parameter int COARSE_W = 4,
  parameter int MED_W    = 6,
  parameter int FINE_W   = 6
) (
  input logic                clk,
  input logic                rst,
  input logic                regWrEn,
  input logic [1:0]          regAddr,
  input logic [FCW_W-1:0]    regWrData,
  input logic [COARSE_W-1:0] tuneCoarse,
  input logic [MED_W-1:0]    tuneMid,
  input logic [FINE_W-1:0]   tuneFine,
  input logic                locked,
  input logic                errSmall
);
  localparam int MID = 1 << (MED_W + FINE_W - 1);

  assert_reset_mid_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ({tuneMid, tuneFine} == (MED_W+FINE_W)'(MID) && !locked));

  assert_coarse_write_R9: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr == 2'd2) |=> tuneCoarse == $past(regWrData[COARSE_W-1:0]));

  assert_coarse_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(regWrEn && regAddr == 2'd2) |=> $stable(tuneCoarse));

  assert_lock_rise_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(errSmall));

  assert_lock_drop_R11: assert property (@(posedge clk) disable iff (rst)
    (locked && !errSmall) |=> !locked);
endmodule

bind ro_adpll_ctrl ro_adpll_checker #(
  .FCW_W(FCW_W), .COARSE_W(COARSE_W), .MED_W(MED_W), .FINE_W(FINE_W)
) u_chk (
  .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .tuneCoarse(tuneCoarse), .tuneMid(tuneMid),
  .tuneFine(tuneFine), .locked(locked), .errSmall(errSmall)
);

// File: tb/ro_adpll_ctrl_bench.sv
module ro_adpll_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [20:0] regWrData = '0;
  logic [31:0] phaseSnap = '0;
  logic [7:0]  edgeCount = '0;
  logic [3:0]  tuneCoarse;
  logic [5:0]  tuneMid, tuneFine;
  logic        locked;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  ro_adpll_ctrl u_ro_adpll_ctrl (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .phaseSnap(phaseSnap), .edgeCount(edgeCount),
    .tuneCoarse(tuneCoarse), .tuneMid(tuneMid), .tuneFine(tuneFine),
    .locked(locked)
  );

  always #2 clk = ~clk;   // 250 MHz

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic int codeNow();
    return int'({tuneMid, tuneFine});
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Ones at (t-15..t) mod 32: transition after bit t
  function automatic logic [31:0] thermo(input int t);
    logic [31:0] v = '0;
    for (int j = 0; j < 16; j++) v[(t - j + 32) % 32] = 1'b1;
    return v;
  endfunction

  task automatic doReset();
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
  endtask

  task automatic wr(input int addr, input int data);
    regWrEn = 1'b1; regAddr = 2'(addr); regWrData = 21'(data);
    tick(1);
    regWrEn = 1'b0;
  endtask

  task automatic applyPhase(input logic [31:0] snap, input int cnt);
    phaseSnap = snap; edgeCount = 8'(cnt);
    tick(3);
  endtask

  task automatic testReset();
    doReset();
    chk("R1 code", codeNow(), 2048);
    chk("R1 mid", int'(tuneMid), 32);
    chk("R1 lock", int'(locked), 0);
    chk("R1 coarse", int'(tuneCoarse), 8);
  endtask

  task automatic testDecode();
    doReset();
    for (int t = 0; t < 32; t++) begin
      applyPhase(thermo(t), 0);
      chk($sformatf("R2 frac t=%0d", t), codeNow(), 2048 - t);
    end
    applyPhase(32'h0, 0);
    chk("R2 no transition", codeNow(), 2048);
  endtask

  task automatic testBubble();
    logic [31:0] s;
    doReset();
    s = thermo(10); s[4] = 1'b0;
    applyPhase(s, 0);
    chk("R3 bubble in ones", codeNow(), 2038);
    s = thermo(10); s[20] = 1'b1;
    applyPhase(s, 0);
    chk("R3 bubble in zeros", codeNow(), 2038);
  endtask

  task automatic testMapping();
    doReset();
    applyPhase(thermo(3), 1);
    chk("R4 count+frac", codeNow(), 2048 - 35);
    chk("R4 fine field", int'(tuneFine), (2048 - 35) % 64);
    applyPhase(thermo(31), 255);
    chk("R4 wrapped positive", codeNow(), 2049);
    // latency: change at one edge visible after the next
    phaseSnap = thermo(7); edgeCount = 8'd0;
    tick(1);
    chk("R4 not yet", codeNow(), 2049);
    tick(1);
    chk("R4 after latency", codeNow(), 2041);
  endtask

  task automatic testSaturate();
    doReset();
    applyPhase(thermo(0), 8'h80);
    chk("R5 low rail", codeNow(), 0);
    applyPhase(thermo(0), 8'hC0);
    chk("R5 high rail", codeNow(), 4095);
  endtask

  task automatic testGain();
    doReset();
    wr(0, 8);
    applyPhase(thermo(20), 0);
    chk("R6 gain half", codeNow(), 2038);
    wr(0, 24);
    applyPhase(thermo(5), 0);
    chk("R6 gain 1.5 floor", codeNow(), 2040);
    wr(0, 0);
    applyPhase(thermo(9), 3);
    chk("R6 gain zero", codeNow(), 2048);
  endtask

  task automatic testRamp();
    int a, b;
    doReset();
    phaseSnap = thermo(0); edgeCount = 8'd0;
    wr(1, 32'h10000);
    tick(4);
    a = codeNow();
    tick(1);
    b = codeNow();
    chk("R7 ramp step", b - a, 32);
  endtask

  task automatic testWrap();
    int ref0, bad;
    doReset();
    phaseSnap = thermo(0); edgeCount = 8'd0;
    wr(1, 32'h10000);
    for (int k = 0; k < 10; k++) begin edgeCount = edgeCount + 8'd1; tick(1); end
    ref0 = codeNow(); bad = 0;
    for (int k = 0; k < 300; k++) begin
      edgeCount = edgeCount + 8'd1;
      tick(1);
      if (codeNow() != ref0 && bad == 0) bad = codeNow();
    end
    chk("R8 tracking across wrap", bad, 0);
  endtask

  task automatic testCoarse();
    doReset();
    wr(2, 13);
    chk("R9 coarse write", int'(tuneCoarse), 13);
    wr(0, 16);
    chk("R9 coarse hold", int'(tuneCoarse), 13);
  endtask

  task automatic testLock();
    doReset();
    applyPhase(thermo(0), 8'h10);
    chk("R10 unlocked on big error", int'(locked), 0);
    phaseSnap = thermo(2); edgeCount = 8'd0;
    tick(16);
    chk("R10 not before run", int'(locked), 0);
    tick(1);
    chk("R10 locked after run", int'(locked), 1);
    edgeCount = 8'h10;
    tick(1);
    chk("R11 still locked", int'(locked), 1);
    tick(1);
    chk("R11 lost", int'(locked), 0);
    wr(3, 2);
    phaseSnap = thermo(2); edgeCount = 8'd0;
    tick(30);
    chk("R10 error equal to threshold", int'(locked), 0);
  endtask

  initial begin
    tick(1);
    testReset();
    testDecode();
    testBubble();
    testMapping();
    testSaturate();
    testGain();
    testRamp();
    testWrap();
    testCoarse();
    testLock();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule